// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This controller collects a set of level-sensitive interrupt lines and turns them into two processor requests. One is a fast request and one is a normal request. Software configures each line with four settings: whether it is enabled, which of the two requests it drives, a priority from 0 to 7 and a security attribute. It also gives each line a 32-bit handler address. For each request output, the controller continuously picks the best pending line and presents that line's handler address in a vector register.

The handler claims the interrupt by writing an acknowledge register. That marks the winning priority as active on that output. Lines of equal or lower priority routed to the same output are then held back until an end-of-interrupt write. Lines marked secure can only be reconfigured by secure-state accesses. Non-secure accesses cannot see their settings and cannot mark a line secure.

The configuration port is a plain write strobe, read address and secure-attribute input. Read data is combinational from the address.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset every line is disabled, non-secure, priority 0, route normal, vector 0. Both request outputs are low, neither output has an active priority, and the default vector register reads 0.
- R2: A request output is high exactly while at least one line is eligible for it. A line is eligible when it is enabled (config bit 0 = 1), its input is high, it is routed to that output, and it is above that output's active priority. The output follows the line level with no latching.
- R3: Config bit 1 selects the route: 1 = fast output, 0 = normal output. A line never drives the other output.
- R4: Priority is config bits [6:4], and 7 is the highest. The winner is the highest-priority eligible line. Among equal priorities the lowest line index wins.
- R5: The vector register of an output reads the 32-bit handler address of that output's current winner. Control index 0 is the normal output and index 1 is the fast output.
- R6: A write to the acknowledge register while the output has a winner makes the winner's priority active on that output. Control index 2 acknowledges the normal output and index 3 the fast output. From the next cycle, lines of equal or lower priority on that output are masked, and a strictly higher line can still raise it.
- R7: A write to the end-of-interrupt register clears the active priority of that output, so masked lines request again. Control index 4 ends the normal output and index 5 the fast output.
- R8: A vector read with no winner returns the default vector register (control index 6). An acknowledge written with no winner changes nothing.
- R9: A non-secure write to a secure line's config or vector has no effect. A non-secure read of those registers returns 0. A non-secure config write always stores the secure bit (config bit 2) as 0. A non-secure write to the default vector is ignored.
- R10: The active state of the fast and normal outputs is independent: a fast line can request while the normal output is acknowledged.

Address map: bits [7:6] select the region (0 = line config, 1 = line vector, 2 = control) and bits [5:0] give the line index or control index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt lines |
| bus_wr_i | input | 1 | Register write strobe |
| bus_sec_i | input | 1 | Access is from the secure state |
| bus_addr_i | input | IDX_W+2 | Register address (region and index) |
| bus_wdata_i | input | VEC_W | Write data |
| bus_rdata_o | output | VEC_W | Read data for bus_addr_i |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with its default of 64 lines and 32-bit vectors. At that size both ends of the index range are reachable: the tie between line 7 and line 63 at top priority, and line 0 at the lowest priority. A single shared configuration, priority equal to index modulo 8, lets one table of input patterns cover ordering, ties and the empty case. Directed sequences then cover masking and unmasking around acknowledge and end-of-interrupt, fast routing during a normal-side active period, and each secure-access rule observed through read-back and request behaviour.

// File: rtl/intc_pkg.sv
// Shared types for the interrupt controller: per-line configuration record.
package intc_pkg;
    localparam int PRIO_W = 3;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;    // 0 lowest .. 7 highest
        logic              secure;  // line owned by secure state
        logic              fiq;     // 1 = fast output, 0 = normal output
        logic              en;      // line enabled
    } src_cfg_t;
endpackage

// File: rtl/intc_src_regs.sv
// Per-line configuration and handler vector storage.
// Assumes at most one write per cycle; non-secure writes to secure lines are dropped
// and non-secure config writes can never set the secure attribute.
module intc_src_regs
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int VEC_W   = 32,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_cfg_i,
    input  logic                           wr_vec_i,
    input  logic                           sec_i,
    input  logic [IDX_W-1:0]               idx_i,
    input  logic [VEC_W-1:0]               wdata_i,
    output src_cfg_t [NUM_SRC-1:0]         cfg_o,
    output logic [NUM_SRC-1:0][VEC_W-1:0]  vec_o
);
    logic allow;

    // Write permission: secure access, or target line not secure.
    assign allow = sec_i || !cfg_o[idx_i].secure;

    // Configuration and vector registers with secure filtering.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                cfg_o[i] <= '0;
                vec_o[i] <= '0;
            end
        end else begin
            if (wr_cfg_i && allow) begin
                cfg_o[idx_i].prio   <= wdata_i[6:4];
                cfg_o[idx_i].secure <= sec_i && wdata_i[2];
                cfg_o[idx_i].fiq    <= wdata_i[1];
                cfg_o[idx_i].en     <= wdata_i[0];
            end
            if (wr_vec_i && allow) begin
                vec_o[idx_i] <= wdata_i;
            end
        end
    end
endmodule

// File: rtl/intc_pick.sv
// Combinational winner selection over candidate lines.
// Highest priority wins; ascending scan with strict compare keeps the lowest index on ties.
module intc_pick
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]             cand_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    output logic                           found_o,
    output logic [IDX_W-1:0]               idx_o,
    output logic [PRIO_W-1:0]              prio_o
);
    // Scan all lines and keep the best candidate seen so far.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        prio_o  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (cand_i[i] && (!found_o || prio_i[i] > prio_o)) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
                prio_o  = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/intc_active.sv
// Holds the single active priority of one request output.
// Acknowledge with a winner loads the winner's priority; end-of-interrupt clears it.
module intc_active
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_i,
    input  logic              eoi_i,
    input  logic              found_i,
    input  logic [PRIO_W-1:0] prio_i,
    output logic              act_o,
    output logic [PRIO_W-1:0] act_prio_o
);
    // Active level register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_o      <= 1'b0;
            act_prio_o <= '0;
        end else if (ack_i && found_i) begin
            act_o      <= 1'b1;
            act_prio_o <= prio_i;
        end else if (eoi_i) begin
            act_o      <= 1'b0;
            act_prio_o <= '0;
        end
    end
endmodule

// File: rtl/prio_vec_intc.sv
// Top of the prioritized vectored interrupt controller.
// Two outputs (index 0 normal, 1 fast), each with its own selector and active level.
// Register read data is combinational from the address; writes take effect at the clock edge.
module prio_vec_intc
    import intc_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int VEC_W    = 32,
    localparam int IDX_W   = $clog2(NUM_SRC),
    localparam int ADDR_W  = IDX_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_wr_i,
    input  logic               bus_sec_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [VEC_W-1:0]   bus_wdata_i,
    output logic [VEC_W-1:0]   bus_rdata_o,
    output logic               irq_o,
    output logic               fiq_o
);
    localparam logic [1:0] RG_CFG  = 2'd0;
    localparam logic [1:0] RG_VEC  = 2'd1;
    localparam logic [1:0] RG_CTRL = 2'd2;
    localparam int C_ACK  = 2;
    localparam int C_EOI  = 4;
    localparam int C_DFLT = 6;

    logic [1:0]                     region;
    logic [IDX_W-1:0]               idx;
    src_cfg_t [NUM_SRC-1:0]         cfg;
    logic [NUM_SRC-1:0][VEC_W-1:0]  vec;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_all;
    logic [1:0][NUM_SRC-1:0]        cand;
    logic [1:0]                     win_found;
    logic [1:0][IDX_W-1:0]          win_idx;
    logic [1:0][PRIO_W-1:0]         win_prio;
    logic [1:0]                     act_v;
    logic [1:0][PRIO_W-1:0]         act_p;
    logic [1:0]                     ack;
    logic [1:0]                     eoi;
    logic [VEC_W-1:0]               dflt_vec;
    logic                           ctrl_wr;

    assign region  = bus_addr_i[ADDR_W-1 -: 2];
    assign idx     = bus_addr_i[IDX_W-1:0];
    assign ctrl_wr = bus_wr_i && (region == RG_CTRL);

    intc_src_regs #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_cfg_i (bus_wr_i && (region == RG_CFG)),
        .wr_vec_i (bus_wr_i && (region == RG_VEC)),
        .sec_i    (bus_sec_i),
        .idx_i    (idx),
        .wdata_i  (bus_wdata_i),
        .cfg_o    (cfg),
        .vec_o    (vec)
    );

    // Candidate lines per output: pending, enabled, routed here, above active level.
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            prio_all[i] = cfg[i].prio;
            for (int o = 0; o < 2; o++) begin
                cand[o][i] = src_i[i] && cfg[i].en && (cfg[i].fiq == 1'(o))
                             && (!act_v[o] || cfg[i].prio > act_p[o]);
            end
        end
    end

    for (genvar o = 0; o < 2; o++) begin : g_out
        assign ack[o] = ctrl_wr && (idx == IDX_W'(C_ACK + o));
        assign eoi[o] = ctrl_wr && (idx == IDX_W'(C_EOI + o));

        intc_pick #(.NUM_SRC(NUM_SRC)) u_pick (
            .cand_i  (cand[o]),
            .prio_i  (prio_all),
            .found_o (win_found[o]),
            .idx_o   (win_idx[o]),
            .prio_o  (win_prio[o])
        );

        intc_active u_act (
            .clk        (clk),
            .rst_n      (rst_n),
            .ack_i      (ack[o]),
            .eoi_i      (eoi[o]),
            .found_i    (win_found[o]),
            .prio_i     (win_prio[o]),
            .act_o      (act_v[o]),
            .act_prio_o (act_p[o])
        );
    end

    assign irq_o = win_found[0];
    assign fiq_o = win_found[1];

    // Default vector register, writable from the secure state only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dflt_vec <= '0;
        end else if (ctrl_wr && bus_sec_i && (idx == IDX_W'(C_DFLT))) begin
            dflt_vec <= bus_wdata_i;
        end
    end

    // Read multiplexer with secure masking of line registers.
    always_comb begin
        bus_rdata_o = '0;
        case (region)
            RG_CFG: begin
                if (bus_sec_i || !cfg[idx].secure) begin
                    bus_rdata_o[6:4] = cfg[idx].prio;
                    bus_rdata_o[2]   = cfg[idx].secure;
                    bus_rdata_o[1]   = cfg[idx].fiq;
                    bus_rdata_o[0]   = cfg[idx].en;
                end
            end
            RG_VEC: begin
                if (bus_sec_i || !cfg[idx].secure) bus_rdata_o = vec[idx];
            end
            RG_CTRL: begin
                if (idx == IDX_W'(0))
                    bus_rdata_o = win_found[0] ? vec[win_idx[0]] : dflt_vec;
                else if (idx == IDX_W'(1))
                    bus_rdata_o = win_found[1] ? vec[win_idx[1]] : dflt_vec;
                else if (idx == IDX_W'(C_DFLT))
                    bus_rdata_o = dflt_vec;
            end
            default: bus_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/intc_checker.sv
// Assertion checker bound to the controller top; observes ports and internal handoffs.
module intc_checker
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = 8,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_wr_i,
    input logic                   bus_sec_i,
    input logic [ADDR_W-1:0]      bus_addr_i,
    input logic                   irq_o,
    input logic                   fiq_o,
    input logic [1:0][IDX_W-1:0]  win_idx,
    input logic [1:0][PRIO_W-1:0] win_prio,
    input logic [1:0]             act_v,
    input logic [1:0][PRIO_W-1:0] act_p,
    input src_cfg_t [NUM_SRC-1:0] cfg
);
    logic [ADDR_W-1:0] a_ack, a_eoi;
    logic              cfg_wr_ns_sec;

    assign a_ack = {2'd2, IDX_W'(2)};
    assign a_eoi = {2'd2, IDX_W'(4)};
    assign cfg_wr_ns_sec = bus_wr_i && !bus_sec_i && (bus_addr_i[ADDR_W-1 -: 2] == 2'd0)
                           && cfg[bus_addr_i[IDX_W-1:0]].secure;

    assert_ack_sets_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == a_ack && irq_o) |=> (act_v[0] && act_p[0] == $past(win_prio[0])));

    assert_masked_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_v[0] && irq_o) |-> (win_prio[0] > act_p[0]));

    assert_eoi_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == a_eoi) |=> !act_v[0]);

    assert_empty_ack_no_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == a_ack && !irq_o) |=> (act_v[0] == $past(act_v[0])));

    assert_routes_disjoint_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && fiq_o && win_idx[0] == win_idx[1]));

    assert_ns_write_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_ns_sec |=> (cfg[$past(bus_addr_i[IDX_W-1:0])] == $past(cfg[bus_addr_i[IDX_W-1:0]])));
endmodule

bind prio_vec_intc intc_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr_i   (bus_wr_i),
    .bus_sec_i  (bus_sec_i),
    .bus_addr_i (bus_addr_i),
    .irq_o      (irq_o),
    .fiq_o      (fiq_o),
    .win_idx    (win_idx),
    .win_prio   (win_prio),
    .act_v      (act_v),
    .act_p      (act_p),
    .cfg        (cfg)
);

// File: tb/prio_vec_intc_tb.sv
module prio_vec_intc_tb;
    localparam int N = 64;
    localparam int VW = 32;
    localparam logic [31:0] DFLT = 32'hDEAD_0000;
    localparam logic [7:0] A_IVEC = 8'h80, A_FVEC = 8'h81, A_IACK = 8'h82;
    localparam logic [7:0] A_IEOI = 8'h84, A_DFLT = 8'h86;

    // Table: {input pattern, expect request, expect winner index}
    localparam int NT = 8;
    localparam logic [70:0] TBL [NT] = '{
        {64'h0,                  1'b0, 6'd0},
        {64'h20,                 1'b1, 6'd5},
        {64'h28,                 1'b1, 6'd5},
        {64'h8080,               1'b1, 6'd7},
        {64'h101,                1'b1, 6'd0},
        {64'hC000_0000_0000_0000, 1'b1, 6'd63},
        {64'h8000_0000_0000_0080, 1'b1, 6'd7},
        {64'h206,                1'b1, 6'd2}
    };

    logic clk = 0, rst_n = 0;
    logic [N-1:0] src = '0;
    logic wr = 0, sec = 0;
    logic [7:0] addr = '0;
    logic [VW-1:0] wdata = '0, rdata;
    logic irq, fiq;
    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    prio_vec_intc u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr_i(wr), .bus_sec_i(sec),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .fiq_o(fiq)
    );

    function automatic logic [31:0] vec_of(int i);
        return 32'hA000_0000 | (32'(i) << 4);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwrite(logic s, logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        wr = 1; sec = s; addr = a; wdata = d;
        @(negedge clk);
        wr = 0; sec = 0;
    endtask

    task automatic bread(logic s, logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        sec = s; addr = a;
        #1 d = rdata;
        sec = 0;
    endtask

    task automatic setsrc(logic [N-1:0] v);
        @(negedge clk);
        src = v;
        #1;
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        #1;
        chk("R1 irq", 32'(irq), 0);
        chk("R1 fiq", 32'(fiq), 0);
        bread(1, A_DFLT, d); chk("R1 default vector", d, 0);
        bread(1, 8'h00, d);  chk("R1 line0 config", d, 0);
        bread(1, A_IVEC, d); chk("R1 idle vector", d, 0);

        // Setup: every line enabled, normal route, priority = index mod 8
        bwrite(1, A_DFLT, DFLT);
        for (int i = 0; i < N; i++) begin
            bwrite(0, 8'(i), 32'(((i % 8) << 4) | 1));
            bwrite(0, 8'h40 | 8'(i), vec_of(i));
        end

        // R2 R4 R5 R8: table of patterns
        for (int t = 0; t < NT; t++) begin
            setsrc(TBL[t][70:7]);
            chk($sformatf("R4 row%0d request", t), 32'(irq), 32'(TBL[t][6]));
            bread(0, A_IVEC, d);
            chk($sformatf("R5 row%0d vector", t), d,
                TBL[t][6] ? vec_of(int'(TBL[t][5:0])) : DFLT);
        end
        setsrc('0);
        chk("R2 level drop", 32'(irq), 0);

        // R3 routing to fast output
        bwrite(0, 8'd10, 32'h23);
        setsrc(64'h400);
        chk("R3 fiq", 32'(fiq), 1);
        chk("R3 irq untouched", 32'(irq), 0);
        bread(0, A_FVEC, d); chk("R3 fast vector", d, vec_of(10));
        bread(0, A_IVEC, d); chk("R3 normal vector default", d, DFLT);

        // R6 acknowledge and masking
        setsrc(64'h8);
        chk("R6 pre-ack", 32'(irq), 1);
        bwrite(0, A_IACK, 0);
        #1 chk("R6 self masked", 32'(irq), 0);
        setsrc(64'h808); chk("R6 equal masked", 32'(irq), 0);
        setsrc(64'h80C); chk("R6 lower masked", 32'(irq), 0);
        setsrc(64'h81C); chk("R6 higher passes", 32'(irq), 1);
        bread(0, A_IVEC, d); chk("R6 higher vector", d, vec_of(4));
        // R10 fast side independent
        setsrc(64'hC1C); chk("R10 fiq during irq active", 32'(fiq), 1);
        setsrc(64'h80C); chk("R6 still masked", 32'(irq), 0);
        // R7 end of interrupt
        bwrite(0, A_IEOI, 0);
        #1 chk("R7 unmasked", 32'(irq), 1);
        bread(0, A_IVEC, d); chk("R7 winner after eoi", d, vec_of(3));

        // R8 empty acknowledge has no effect
        setsrc('0);
        bwrite(0, A_IACK, 0);
        setsrc(64'h2);
        chk("R8 no active after empty ack", 32'(irq), 1);
        bread(0, A_IVEC, d); chk("R8 vector", d, vec_of(1));

        // R9 security rules
        setsrc('0);
        bwrite(0, 8'd20, 32'h05);
        bread(0, 8'd20, d); chk("R9 ns cannot set secure", d, 32'h01);
        bwrite(1, 8'd21, 32'h75);
        bwrite(0, 8'd21, 32'h00);
        bwrite(0, 8'h40 | 8'd21, 32'h0);
        setsrc(64'h20_0000);
        chk("R9 ns cfg write dropped", 32'(irq), 1);
        bread(0, A_IVEC, d); chk("R9 ns vec write dropped", d, vec_of(21));
        bread(0, 8'd21, d); chk("R9 ns read hidden", d, 0);
        bread(1, 8'd21, d); chk("R9 secure read", d, 32'h75);
        bwrite(0, A_DFLT, 32'h1234);
        bread(0, A_DFLT, d); chk("R9 ns default write dropped", d, DFLT);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule